// File: doc/BRIEF.md
# Random Table Update Engine

This block runs a random-memory-update workload in hardware. It holds a 64-bit pseudo-random generator. Each step moves the generator left by one bit and folds in a small constant whenever the top bit was set. The low bits of every new value select an entry in a local table of 64-bit words, and that entry is replaced by itself XOR the same value. The table is a synchronous single-port memory modelled inside the block. Each update therefore takes one read cycle followed by one write cycle.

A run starts with a one-cycle `start` pulse that carries a seed, an update count and the table size as a power of two. The engine first fills the table so that every entry holds its own index, writing one entry per cycle. It then performs the requested number of updates. When the last write is done it raises `done` for one cycle and leaves the final generator value on `rand_out`.

Every table write is visible on a write-observation port, so the surrounding logic can follow the sequence of writes.

Top module: `rtu_engine`

## Requirements
- R1: After reset, `busy`, `done` and `tbl_wr_en` are 0 and `rand_out` is 0.
- R2: A `start` pulse while idle loads `seed` into the generator, and `busy` is 1 from the following cycle.
- R3: The fill phase writes entry i with the value i (zero-extended) for i = 0 up to size-1 in ascending order, one write per cycle, starting the cycle after `start`.
- R4: Each generator step produces `{prev[62:0],1'b0}` XOR 64'd7 when `prev[63]` is 1, and XOR 0 otherwise.
- R5: The table index is the low `log2_size` bits of the new generator value. A `log2_size` greater than ADDR_W is treated as ADDR_W.
- R6: Each update reads the selected entry and, in the next cycle, writes back entry XOR value. A run therefore lasts size + 2*count busy cycles.
- R7: Two consecutive updates to the same index see each other: the second read returns the first write's result.
- R8: `done` is 1 for exactly one cycle, the cycle after the last write. In that cycle `busy` is 0 and `rand_out` holds the last generated value.
- R9: With an update count of 0, the fill runs, then `done` pulses with no update writes, and `rand_out` equals the seed.
- R10: A `start` pulse while `busy` is 1 is ignored: the generator, the count and the write sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle run request |
| seed | input | 64 | Initial generator value |
| upd_count | input | CNT_W | Number of updates in the run |
| log2_size | input | LG_W | Table size as a power of two |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rand_out | output | 64 | Current generator value |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_idx | output | ADDR_W | Table write index |
| tbl_wr_val | output | 64 | Table write data |

## Verification
The bench targets the following corner cases, and what a faulty design would show in each:

- **Single-entry table.** Every update hits the same index. A design that read stale data would write the wrong XOR chain.
- **Oversized size field.** A design that failed to clamp it would fold indices wrongly.
- **Zero update count.** A design could emit a spurious update or hang instead of pulsing `done`.
- **Restart during a run.** A mid-run `start` must not reload the seed. A design that reloaded it would diverge from the expected write stream and final value.
- **Sign bit in the seed.** Seeds with the top bit set exercise the feedback constant. A wrong fold would corrupt the whole write stream.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
  localparam int RTU_DW = 64;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_READ,
    ST_WRITE
  } rtu_state_e;

  // one generator step: left shift, fold in 7 when the old top bit was set
  function automatic logic [RTU_DW-1:0] rtu_step(input logic [RTU_DW-1:0] v);
    logic [RTU_DW-1:0] fold;
    fold = v[RTU_DW-1] ? RTU_DW'(7) : '0;
    return {v[RTU_DW-2:0], 1'b0} ^ fold;
  endfunction

  // read-modify-write combine
  function automatic logic [RTU_DW-1:0] rtu_merge(input logic [RTU_DW-1:0] old_v,
                                                  input logic [RTU_DW-1:0] rnd);
    return old_v ^ rnd;
  endfunction
endpackage

// File: rtl/rtu_prng.sv
module rtu_prng
  import rtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RTU_DW-1:0] seed,
  input  logic              step,
  output logic [RTU_DW-1:0] rnd_cur,
  output logic [RTU_DW-1:0] rnd_next
);
  logic [RTU_DW-1:0] rnd_q;

  assign rnd_next = rtu_step(rnd_q);
  assign rnd_cur  = rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rnd_q <= '0;
    else if (load) rnd_q <= seed;
    else if (step) rnd_q <= rnd_next;
  end

  AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> rnd_q[RTU_DW-1:3] == $past(rnd_q[RTU_DW-2:2])); // R4
  AST_STEP_FOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && rnd_q[RTU_DW-1]) |=> rnd_q[2:0] == ({$past(rnd_q[1:0]), 1'b0} ^ 3'd7)); // R4
  AST_STEP_FOLD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !rnd_q[RTU_DW-1]) |=> rnd_q[2:0] == {$past(rnd_q[1:0]), 1'b0}); // R4
endmodule

// File: rtl/rtu_table.sv
module rtu_table
  import rtu_pkg::*;
#(
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [RTU_DW-1:0] wdata,
  output logic [RTU_DW-1:0] rdata
);
  logic [RTU_DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/rtu_ctrl.sv
module rtu_ctrl
  import rtu_pkg::*;
#(
  parameter int AW  = 6,
  parameter int CW  = 16,
  parameter int LGW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     upd_count,
  input  logic [LGW-1:0]    log2_size,
  input  logic [RTU_DW-1:0] rnd_cur,
  input  logic [RTU_DW-1:0] rnd_next,
  input  logic [RTU_DW-1:0] rd_data,
  output logic              load,
  output logic              step,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [RTU_DW-1:0] mem_wdata,
  output logic              busy,
  output logic              done
);
  rtu_state_e    st_q;
  logic [AW-1:0] idx_q, mask_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [LGW-1:0] lg_eff;
  logic [AW-1:0]  ones;

  // named events for the assertions
  logic fill_wr, upd_rd, upd_wr, fill_last, upd_last;

  assign ones      = '1;
  assign lg_eff    = (int'(log2_size) > AW) ? LGW'(AW) : log2_size;
  assign fill_wr   = (st_q == ST_FILL);
  assign upd_rd    = (st_q == ST_READ);
  assign upd_wr    = (st_q == ST_WRITE);
  assign fill_last = fill_wr && (idx_q == mask_q);
  assign upd_last  = upd_wr && (cnt_q == CW'(1));
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign load      = start && !busy;
  assign step      = upd_rd;

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st_q)
      ST_FILL: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = idx_q;
        mem_wdata = {{(RTU_DW-AW){1'b0}}, idx_q};
      end
      ST_READ: begin
        mem_en   = 1'b1;
        mem_addr = rnd_next[AW-1:0] & mask_q;
      end
      ST_WRITE: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = rnd_cur[AW-1:0] & mask_q;
        mem_wdata = rtu_merge(rd_data, rnd_cur);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      mask_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          mask_q <= ones >> (AW - int'(lg_eff));
          cnt_q  <= upd_count;
          idx_q  <= '0;
          st_q   <= ST_FILL;
        end
        ST_FILL: begin
          idx_q <= idx_q + 1'b1;
          if (fill_last) begin
            if (cnt_q == '0) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_READ;
            end
          end
        end
        ST_READ: st_q <= ST_WRITE;
        ST_WRITE: begin
          cnt_q <= cnt_q - 1'b1;
          if (upd_last) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_READ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_wr |-> $past(upd_rd)); // R6
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    upd_rd |=> upd_wr); // R6
  AST_FILL_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_wr && $past(fill_wr)) |-> mem_addr == $past(mem_addr) + 1'b1); // R3
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr & ~mask_q) == '0); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
endmodule

// File: rtl/rtu_engine.sv
module rtu_engine
  import rtu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16,
  localparam int LG_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [63:0]       seed,
  input  logic [CNT_W-1:0]  upd_count,
  input  logic [LG_W-1:0]   log2_size,
  output logic              busy,
  output logic              done,
  output logic [63:0]       rand_out,
  output logic              tbl_wr_en,
  output logic [ADDR_W-1:0] tbl_wr_idx,
  output logic [63:0]       tbl_wr_val
);
  logic              load, step, mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [RTU_DW-1:0] mem_wdata, mem_rdata, rnd_cur, rnd_next;

  rtu_prng u_prng (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .step(step),
    .rnd_cur(rnd_cur), .rnd_next(rnd_next)
  );

  rtu_ctrl #(.AW(ADDR_W), .CW(CNT_W), .LGW(LG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .upd_count(upd_count),
    .log2_size(log2_size), .rnd_cur(rnd_cur), .rnd_next(rnd_next),
    .rd_data(mem_rdata), .load(load), .step(step), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done)
  );

  rtu_table #(.AW(ADDR_W)) u_table (
    .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  assign rand_out   = rnd_cur;
  assign tbl_wr_en  = mem_en & mem_we;
  assign tbl_wr_idx = mem_addr;
  assign tbl_wr_val = mem_wdata;

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step) |=> $stable(rand_out)); // R10
  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && rand_out == $past(seed))); // R2
endmodule

// File: tb/rtu_engine_tb_top.sv
`timescale 1ns/1ps
module rtu_engine_tb_top;
  localparam int AW = 6;
  localparam int CW = 16;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [63:0]   seed = '0;
  logic [CW-1:0] upd_count = '0;
  logic [LW-1:0] log2_size = '0;
  logic          busy, done, tbl_wr_en;
  logic [63:0]   rand_out, tbl_wr_val;
  logic [AW-1:0] tbl_wr_idx;

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R3";

  typedef struct {
    logic [AW-1:0] idx;
    logic [63:0]   val;
  } wr_item_t;
  wr_item_t exp_q[$];

  always #2.5 clk = ~clk;

  rtu_engine #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .upd_count(upd_count), .log2_size(log2_size), .busy(busy), .done(done),
    .rand_out(rand_out), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_val(tbl_wr_val)
  );

  // independent generator model (R4)
  function automatic logic [63:0] mdl_next(input logic [63:0] v);
    logic [63:0] k;
    k = (v >> 63) != 0 ? 64'h7 : 64'h0;
    return (v << 1) ^ k;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every observed write
  always @(negedge clk) begin
    if (rst_n && tbl_wr_en) begin
      if (exp_q.size() == 0) begin
        chk({cur_req, " unexpected write"}, {58'd0, tbl_wr_idx}, 64'hFFFF_FFFF_FFFF_FFFF);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        chk({cur_req, " idx"}, {58'd0, tbl_wr_idx}, {58'd0, e.idx});
        chk({cur_req, " val"}, tbl_wr_val, e.val);
      end
    end
  end

  task automatic run_case(input logic [63:0] sd, input int cnt, input int lg,
                          input string req, input bit poke);
    logic [63:0] tbl [64];
    logic [63:0] r;
    int eff, size, cyc;
    eff  = (lg > AW) ? AW : lg;
    size = 1 << eff;
    for (int i = 0; i < size; i++) begin
      tbl[i] = 64'(i);
      exp_q.push_back('{AW'(i), 64'(i)});
    end
    r = sd;
    for (int n = 0; n < cnt; n++) begin
      int a;
      r = mdl_next(r);
      a = int'(r % 64'(size));
      tbl[a] = tbl[a] ^ r;
      exp_q.push_back('{AW'(a), tbl[a]});
    end
    cur_req = req;
    @(negedge clk);
    start = 1'b1; seed = sd; upd_count = CW'(cnt); log2_size = LW'(lg);
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", {63'd0, busy}, 64'd1);
    chk("R2 seed loaded", rand_out, sd);
    cyc = 1;
    forever begin
      @(negedge clk);
      if (poke && cyc == 3) begin
        start = 1'b1; seed = ~sd; upd_count = CW'(1); log2_size = '0;
      end else begin
        start = 1'b0;
      end
      if (done) break;
      cyc++;
      if (cyc > 20000) begin
        chk("R8 run never ended", 64'(cyc), 64'(size + 2 * cnt));
        break;
      end
    end
    start = 1'b0;
    chk({req, " R6 run length"}, 64'(cyc), 64'(size + 2 * cnt));
    chk("R8 busy low with done", {63'd0, busy}, 64'd0);
    chk({req, " R8 final value"}, rand_out, r);
    chk({req, " R6 all writes seen"}, 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    @(negedge clk);
    chk("R8 done single cycle", {63'd0, done}, 64'd0);
    chk("R8 value held", rand_out, r);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", {63'd0, busy}, 64'd0);
    chk("R1 done at reset", {63'd0, done}, 64'd0);
    chk("R1 rand_out at reset", rand_out, 64'd0);
    chk("R1 no write at reset", {63'd0, tbl_wr_en}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3 R4 R6: top bit set in the seed exercises the fold
    run_case(64'h8000_0000_0000_0001, 20, 4, "R3/R4", 1'b0);
    run_case(64'h1234_5678_9ABC_DEF0, 40, 6, "R4 R6", 1'b0);
    // R7: single-entry table, every update hits index 0
    run_case(64'hFFFF_0000_FFFF_0000, 12, 0, "R7", 1'b0);
    // R5: size field above ADDR_W clamps to ADDR_W
    run_case(64'hC3C3_A5A5_0F0F_7E7E, 30, 7, "R5", 1'b0);
    // R9: zero updates
    run_case(64'hDEAD_BEEF_0000_0042, 0, 3, "R9", 1'b0);
    // R10: a start pulse in mid-run must be ignored
    run_case(64'hF000_0000_0000_0F00, 5, 4, "R10", 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule